// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. It watches the clock line (SCL) and the data line (SDA), both sampled by the system clock. It recognises start and stop conditions and decodes an address byte. That byte carries a fixed device-type pattern and two chip-select bits, which are compared against two strap pins. The block then serves reads and writes on an on-chip byte array. SDA is driven only by pulling it low. The pull-low output is meant to be combined with the bus as a wired-AND, and a pull-up supplies the high level.

A write transfer sends the address byte with the direction bit clear, then a high and a low word-address byte, then one or more data bytes. Data bytes fill one page of the array and wrap inside that page. A read returns bytes from an internal address counter, and the counter advances after every byte. There are two ways to start a read. The master can read at the current counter value directly. Or it can first load the counter with a dummy write and then issue a repeated start with the direction bit set. The master acknowledges each byte it wants to keep receiving and withholds the acknowledge on the last one.

The array holds 2^ADDR_W bytes arranged as pages of 2^OFF_W bytes. The full-size memory uses ADDR_W = 15, which gives 512 pages of 64 bytes. The default build uses a smaller array so that it elaborates quickly.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start. It is recognised in any state, including in the middle of a byte. After it, the block expects a fresh address byte.
- R2: A rising SDA while SCL is high is a stop. After it, the block releases SDA (sda_pull_o = 0) and ignores the bus until the next start. After reset, SDA is also released.
- R3: The address byte is taken MSB first. Bits 7:4 must be 1010, bit 3 must be 0, and bits 2:1 must equal sel_i[1:0]. Bit 0 = 1 requests a read and 0 requests a write. When the byte matches, the block pulls SDA low for the whole ninth clock.
- R4: On a mismatching address byte, the block gives no acknowledge. It then acknowledges nothing and writes nothing until the next start.
- R5: In a write, the block acknowledges every byte after the address byte: both word-address bytes and every data byte.
- R6: The word address is formed as {high byte, low byte}, and only the lowest ADDR_W bits are kept. Low-byte bits 7:6 are the lowest page bits, and bits 5:0 (OFF_W bits) are the offset within a page. Bits of the high byte above ADDR_W have no effect.
- R7: A data byte received in a write is stored at the current internal address.
- R8: After each stored byte, only the OFF_W-bit offset advances. It wraps from the last byte of the page to the first byte of the same page, and the page field does not change.
- R9: A read sends eight bits MSB first while SCL is low, then releases SDA for the ninth clock. When the master acknowledges, the next byte follows.
- R10: When the master does not acknowledge a read byte, the block stops driving SDA and stays released until the next start.
- R11: The internal address advances by one after every byte sent, including the last, unacknowledged one. A read that gives no word address continues from that value.
- R12: During reads, the internal address wraps from the last byte of the array to address 0.
- R13: SDA is sampled on rising SCL, and sda_pull_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sel_i | input | 2 | Chip-select straps compared with address bits 2:1 |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bound checker checks the following on every cycle:
- a stop always leaves SDA released on the next cycle;
- the pull-low output never changes while the synchronised SCL is high;
- the idle state never drives SDA;
- a start always restarts address reception with an empty bit count;
- the bit count never goes past eight;
- an array write happens only for a data byte of a write transfer.

Other behaviours depend on byte values carried across whole transfers, so only the bench scenarios can show them:
- the address-byte compare against the straps;
- page-local wrap during writes;
- the counter continuing after an unacknowledged read byte;
- the wrap at the top of the array;
- ignoring of traffic after a mismatching address.

// File: rtl/sep_pkg.sv
package sep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } bus_st_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } rx_kind_t;

  localparam logic [3:0] DEV_TYPE  = 4'b1010;
  localparam logic       DEV_FIXED = 1'b0;

endpackage

// File: rtl/sep_line_sync.sv
module sep_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_prev
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= {STAGES{RST_VAL}};
      q_prev <= RST_VAL;
    end else begin
      sr     <= {sr[STAGES-2:0], d};
      q_prev <= sr[STAGES-1];
    end
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/sep_byte_ram.sv
module sep_byte_ram #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/sep_addr_ctr.sv
module sep_addr_ctr #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc_full,
  input  logic              inc_page,
  output logic [ADDR_W-1:0] addr
);

  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] page_f;
  logic [OFF_W-1:0]  off_f;

  assign page_f = addr[ADDR_W-1:OFF_W];
  assign off_f  = addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (ld) begin
      addr <= ld_val;
    end else if (inc_full) begin
      addr <= addr + {{(ADDR_W-1){1'b0}}, 1'b1};
    end else if (inc_page) begin
      addr <= {page_f, off_f + {{(OFF_W-1){1'b0}}, 1'b1}};
    end
  end

endmodule

// File: rtl/sep_bus_fsm.sv
module sep_bus_fsm
  import sep_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              scl_p,
  input  logic              sda_s,
  input  logic              sda_p,
  input  logic [1:0]        sel,
  input  logic [7:0]        rd_byte,
  output logic              sda_pull,
  output logic              ld,
  output logic [ADDR_W-1:0] ld_val,
  output logic              inc_full,
  output logic              inc_page,
  output logic              we,
  output logic [7:0]        wdata,
  output bus_st_t           st,
  output rx_kind_t          kind,
  output logic [3:0]        cnt,
  output logic              rw
);

  localparam int HI_W = ADDR_W - 8;

  logic scl_rise, scl_fall, start_c, stop_c;
  logic [6:0]      sh;
  logic [6:0]      tx_sh;
  logic [HI_W-1:0] hi_q;
  logic            ack_q;
  logic [7:0]      rx_byte;
  logic            dev_match;
  rx_kind_t        kind_nxt;

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign rx_byte  = {sh, sda_s};

  assign dev_match = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3] == DEV_FIXED)
                   && (rx_byte[2:1] == sel);

  always_comb begin
    case (kind)
      K_DEV:   kind_nxt = K_AHI;
      K_AHI:   kind_nxt = K_ALO;
      default: kind_nxt = K_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind     <= K_DEV;
      cnt      <= '0;
      rw       <= 1'b0;
      sh       <= '0;
      tx_sh    <= '0;
      hi_q     <= '0;
      ack_q    <= 1'b0;
      sda_pull <= 1'b0;
      ld       <= 1'b0;
      ld_val   <= '0;
      inc_full <= 1'b0;
      inc_page <= 1'b0;
      we       <= 1'b0;
      wdata    <= '0;
    end else begin
      ld       <= 1'b0;
      inc_full <= 1'b0;
      inc_page <= 1'b0;
      we       <= 1'b0;
      if (stop_c) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_c) begin
        st       <= ST_RX;
        kind     <= K_DEV;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= rx_byte[6:0];
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                case (kind)
                  K_DEV: begin
                    ack_q <= dev_match;
                    rw    <= sda_s;
                  end
                  K_AHI: begin
                    hi_q  <= rx_byte[HI_W-1:0];
                    ack_q <= 1'b1;
                  end
                  K_ALO: begin
                    ld     <= 1'b1;
                    ld_val <= {hi_q, rx_byte};
                    ack_q  <= 1'b1;
                  end
                  default: begin
                    we    <= 1'b1;
                    wdata <= rx_byte;
                    ack_q <= 1'b1;
                  end
                endcase
              end
            end else if (scl_fall && cnt == 4'd8) begin
              if (ack_q) begin
                st       <= ST_ACK;
                sda_pull <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_DATA) inc_page <= 1'b1;
              if (kind == K_DEV && rw) begin
                st       <= ST_TX;
                tx_sh    <= rd_byte[6:0];
                sda_pull <= ~rd_byte[7];
              end else begin
                st       <= ST_RX;
                kind     <= kind_nxt;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                st       <= ST_TXACK;
                sda_pull <= 1'b0;
              end else begin
                tx_sh    <= {tx_sh[5:0], 1'b0};
                sda_pull <= ~tx_sh[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              inc_full <= 1'b1;
              ack_q    <= ~sda_s;
            end else if (scl_fall) begin
              if (ack_q) begin
                st       <= ST_TX;
                cnt      <= '0;
                tx_sh    <= rd_byte[6:0];
                sda_pull <= ~rd_byte[7];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_pull <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import sep_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int OFF_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] sel_i,
  output logic       sda_pull_o
);

  logic              scl_s, scl_p, sda_s, sda_p;
  logic              ld, inc_full, inc_page, we_w, rw_w;
  logic [ADDR_W-1:0] ld_val, addr;
  logic [7:0]        wdata, rd_byte;
  logic [3:0]        cnt_w;
  bus_st_t           st_w;
  rx_kind_t          kind_w;

  sep_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s), .q_prev(scl_p)
  );

  sep_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_i), .q(sda_s), .q_prev(sda_p)
  );

  sep_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
    .sel(sel_i), .rd_byte(rd_byte),
    .sda_pull(sda_pull_o),
    .ld(ld), .ld_val(ld_val), .inc_full(inc_full), .inc_page(inc_page),
    .we(we_w), .wdata(wdata),
    .st(st_w), .kind(kind_w), .cnt(cnt_w), .rw(rw_w)
  );

  sep_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val),
    .inc_full(inc_full), .inc_page(inc_page), .addr(addr)
  );

  sep_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(we_w), .addr(addr), .wdata(wdata), .rdata(rd_byte)
  );

endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk
  import sep_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       scl_p,
  input logic       sda_s,
  input logic       sda_p,
  input logic       sda_pull_o,
  input bus_st_t    st_w,
  input rx_kind_t   kind_w,
  input logic [3:0] cnt_w,
  input logic       we_w,
  input logic       rw_w
);

  logic bus_start, bus_stop;
  assign bus_start = scl_p & scl_s & sda_p & ~sda_s;
  assign bus_stop  = scl_p & scl_s & ~sda_p & sda_s;

  // R2
  release_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !sda_pull_o);

  // R13
  pull_moves_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull_o) || $fell(sda_pull_o)) |-> !scl_s);

  // R10
  idle_is_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (st_w == ST_IDLE) |-> !sda_pull_o);

  // R1
  start_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (st_w == ST_RX && kind_w == K_DEV && cnt_w == 4'd0));

  // R9
  bit_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_w <= 4'd8);

  // R4
  write_only_data_chk: assert property (@(posedge clk) disable iff (rst)
    we_w |-> (!rw_w && kind_w == K_DATA));

endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk u_chk (
  .clk(clk), .rst(rst),
  .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
  .sda_pull_o(sda_pull_o),
  .st_w(st_w), .kind_w(kind_w), .cnt_w(cnt_w), .we_w(we_w), .rw_w(rw_w)
);

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;

  localparam int Q      = 12;
  localparam int AW     = 12;
  localparam int OFFW   = 6;
  localparam int WDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] sel = 2'b10;
  logic       sda_pull;
  logic       sda_line;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  serial_eeprom_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sel_i(sel), .sda_pull_o(sda_pull)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] model [0:(1<<AW)-1];
  logic [AW-1:0] cur;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_byte;
  event       got_ev;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected byte", int'(got_byte), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got_byte === e, t, int'(got_byte), int'(e));
      end
    end
  end

  // R13 observer: the pull output may only move while SCL is low
  int   r13_bad = 0;
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (!rst && (sda_pull !== prev_pull) && scl) r13_bad++;
    prev_pull = sda_pull;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(Q); sda_m = 1'b1;
    wq(Q); scl = 1'b1;
    wq(Q); sda_m = 1'b0;
    wq(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(Q); sda_m = 1'b0;
    wq(Q); scl = 1'b1;
    wq(Q); sda_m = 1'b1;
    wq(Q);
  endtask

  task automatic wbit(input logic b);
    wq(Q); sda_m = b;
    wq(Q); scl = 1'b1;
    wq(2*Q); scl = 1'b0;
  endtask

  task automatic rbit(output logic b);
    wq(Q); sda_m = 1'b1;
    wq(Q); scl = 1'b1;
    wq(Q); b = sda_line;
    wq(Q); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(a);
    acked = (a == 1'b0);
  endtask

  task automatic recv_byte(input bit give_ack);
    logic [7:0] v;
    logic x;
    for (int i = 7; i >= 0; i--) begin
      rbit(x);
      v[i] = x;
    end
    got_byte = v;
    -> got_ev;
    wbit(!give_ack);
  endtask

  task automatic write_seq(input logic [7:0] hi, input logic [7:0] lo,
                           input int n, input logic [31:0] data);
    bit a;
    logic [AW-1:0] ad;
    logic [15:0] full;
    full = {hi, lo};
    ad = full[AW-1:0];
    bus_start();
    send_byte(8'hA4, a); check(a, "R3 address ack", a, 1);
    send_byte(hi, a);    check(a, "R5 high word ack", a, 1);
    send_byte(lo, a);    check(a, "R5 low word ack", a, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = data[31-8*i -: 8];
      send_byte(d, a);   check(a, "R5 data ack", a, 1);
      model[ad] = d;
      ad = {ad[AW-1:OFFW], ad[OFFW-1:0] + 1'b1};
    end
    bus_stop();
  endtask

  task automatic read_at(input logic [7:0] hi, input logic [7:0] lo,
                         input int n, input string tag);
    bit a;
    logic [15:0] full;
    full = {hi, lo};
    cur = full[AW-1:0];
    bus_start();
    send_byte(8'hA4, a); check(a, "R3 dummy write ack", a, 1);
    send_byte(hi, a);    check(a, "R5 high word ack", a, 1);
    send_byte(lo, a);    check(a, "R5 low word ack", a, 1);
    bus_start();
    send_byte(8'hA5, a); check(a, "R3 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[cur]); tag_q.push_back(tag);
      recv_byte(i < n - 1);
      cur = cur + 1'b1;
    end
    wq(Q);
    check(sda_pull == 1'b0, "R10 released after nack", sda_pull, 0);
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string tag);
    bit a;
    bus_start();
    send_byte(8'hA5, a); check(a, "R3 read address ack", a, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[cur]); tag_q.push_back(tag);
      recv_byte(i < n - 1);
      cur = cur + 1'b1;
    end
    bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", WDOG);
    finish_run();
  end

  initial begin
    bit a;
    wq(8);
    rst = 1'b0;
    wq(4);
    // R2: released after reset
    check(sda_pull == 1'b0, "R2 reset release", sda_pull, 0);

    // R6 R7: high-byte bits above ADDR_W ignored; byte write lands at 0x145
    write_seq(8'h71, 8'h45, 1, 32'h3C00_0000);
    read_at(8'h01, 8'h45, 1, "R6 R7 byte write/readback");

    // R8: page write wraps within page 2, 0x0C0 untouched
    write_seq(8'h00, 8'hC0, 2, 32'h5A6B_0000);
    write_seq(8'h00, 8'hBE, 4, 32'h1122_3344);
    read_at(8'h00, 8'h80, 2, "R8 R9 page wrap data");
    // R11: sequential read crosses page, then current-address read continues
    read_at(8'h00, 8'hBE, 3, "R11 sequential read");
    cur_read(1, "R11 current address after nack");

    // R12: wrap from top of array to 0
    write_seq(8'h0F, 8'hFF, 1, 32'h9900_0000);
    write_seq(8'h00, 8'h00, 1, 32'h7700_0000);
    read_at(8'h0F, 8'hFF, 2, "R12 array wrap");

    // R4: wrong select bits, following bytes ignored
    bus_start();
    send_byte(8'hA2, a); check(!a, "R4 select mismatch nack", a, 0);
    send_byte(8'h00, a); check(!a, "R4 ignored byte", a, 0);
    send_byte(8'h80, a); check(!a, "R4 ignored byte", a, 0);
    send_byte(8'hEE, a); check(!a, "R4 ignored byte", a, 0);
    bus_stop();
    check(sda_pull == 1'b0, "R2 release after stop", sda_pull, 0);
    read_at(8'h00, 8'h80, 1, "R4 array unchanged");

    // R3: wrong device type, wrong fixed bit
    bus_start();
    send_byte(8'hB4, a); check(!a, "R3 type mismatch nack", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hAC, a); check(!a, "R3 fixed bit mismatch nack", a, 0);
    bus_stop();

    // R1: start in the middle of a byte
    bus_start();
    send_byte(8'hA4, a); check(a, "R1 first address ack", a, 1);
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0);
    bus_start();
    send_byte(8'hA4, a); check(a, "R1 address ack after restart", a, 1);
    send_byte(8'h00, a); check(a, "R1 high word ack", a, 1);
    send_byte(8'h81, a); check(a, "R1 low word ack", a, 1);
    bus_start();
    send_byte(8'hA5, a); check(a, "R1 read ack", a, 1);
    cur = 12'h081;
    exp_q.push_back(model[cur]); tag_q.push_back("R1 read after restart");
    recv_byte(1'b0);
    bus_stop();

    wq(Q);
    check(exp_q.size() == 0, "R9 all expected bytes seen", exp_q.size(), 0);
    check(r13_bad == 0, "R13 pull changed with SCL high", r13_bad, 0);
    finish_run();
  end

endmodule